// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, once per received frame, whether the frame is kept. The receive path presents the 48-bit destination address together with a one-cycle strobe. One clock later the filter returns an accept flag and the rule or rules that matched: an exact-match slot and its index, a hash hit, a broadcast hit, or the promiscuous copy-all rule. Bit 0 of the address is the least significant bit of the first byte on the wire, which is the group (multicast) indicator. Bit 47 is the most significant bit of the last byte.

Software programs the filter through a 32-bit write-only port with a word address. The port reaches a configuration word, a 64-bit hash table split over two words, and a set of exact-match slots, each held in a low word and a high word. The hash folds the address into a 6-bit table index. Every sixth address bit is XORed into the same index bit. The addressed table bit is then qualified by the group bit and by the unicast or multicast hash enable.

The result stage is a two-state machine. `ST_IDLE` holds the outputs cleared. The transition *capture* goes from `ST_IDLE` to `ST_REPORT` on a strobe. *Hold* stays in `ST_REPORT` when strobes arrive back to back. *Drain* returns from `ST_REPORT` to `ST_IDLE` when no strobe arrives. The outputs are valid only in `ST_REPORT`.

Top module: `rx_addr_filter`

## Requirements
- R1: The outputs are registered. `res_valid` is 1 exactly in the cycle after a cycle in which `da_valid` was 1. While `res_valid` is 0, `accept` and every `hit_*` output are 0.
- R2: Configuration word 0 bit 3 is copy-all. When it is set, every frame is accepted and `hit_all` is 1.
- R3: An all-ones address is broadcast. It sets `hit_bcast` and is accepted unless configuration word 0 bit 2 (broadcast block) is set. A broadcast address never produces an exact-match or hash hit.
- R4: Slot k uses two words. Its low word sits at word address 4+2k and carries address bits 31:0, with the first byte in bits 7:0. Its high word sits at 5+2k and carries address bits 47:32 in bits 15:0. When an enabled slot equals the address, `hit_spec` is 1, `hit_idx` is k, and the frame is accepted.
- R5: A write to a slot's high word enables that slot. A write to its low word disables it until the next write to the high word.
- R6: When several enabled slots match, `hit_idx` reports the lowest index.
- R7: Hash index bit i (0..5) is the XOR of address bits i, i+6, …, i+42. This index selects one bit of the 64-bit table.
- R8: A unicast hash hit needs all of: configuration word 0 bit 0 set, address bit 0 equal to 0, and the indexed table bit set.
- R9: A multicast hash hit needs all of: configuration word 0 bit 1 set, address bit 0 equal to 1, and the indexed table bit set. An all-ones table therefore accepts every multicast address.
- R10: Word 2 holds table bits 31:0 and word 3 holds table bits 63:32.
- R11: Bits 31:16 of a slot's high word are ignored.
- R12: A write in the same cycle as a strobe does not affect that frame. It takes effect for the next frame.
- R13: After reset, the configuration is 0, the table is clear and all slots are disabled. A non-broadcast frame is therefore rejected and a broadcast frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | REG_AW | Register word address |
| cfg_wr_data | input | 32 | Register write data |
| da_valid | input | 1 | Destination address strobe, one cycle per frame |
| da | input | 48 | Destination address, bit 0 = first bit received |
| res_valid | output | 1 | Result valid, one cycle after `da_valid` |
| accept | output | 1 | Frame accepted |
| hit_spec | output | 1 | An exact-match slot matched |
| hit_idx | output | IDX_W | Lowest matching slot index |
| hit_hash | output | 1 | Unicast or multicast hash hit |
| hit_bcast | output | 1 | Broadcast rule accepted the frame |
| hit_all | output | 1 | Copy-all rule active |

## Verification
The bench builds the filter with its default parameters: four slots, a 6-bit hash and a 5-bit register address. With four slots, the bench can program the same address into several slots, so the lowest-index choice can be exercised. It can also re-enable and disable individual slots. The full 64-entry table lets the bench choose addresses whose hash index falls in the upper table word as well as the lower one. It can also fill the table with all ones to accept every multicast address.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } rxf_state_e;

    typedef struct packed {
        logic uc_hash_en;
        logic mc_hash_en;
        logic bcast_block;
        logic accept_all;
    } rxf_cfg_t;

    localparam int CFG_UC_BIT    = 0;
    localparam int CFG_MC_BIT    = 1;
    localparam int CFG_BLOCK_BIT = 2;
    localparam int CFG_ALL_BIT   = 3;

    localparam int CFG_WORD      = 0;
    localparam int TABLE_BASE    = 2;
    localparam int ENTRY_BASE    = 4;

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int REG_AW   = 5,
    parameter int HASH_W   = 6,
    localparam int TBL_BITS = 1 << HASH_W,
    localparam int TBL_WORDS = (TBL_BITS + 31) / 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   wr_addr,
    input  logic [31:0]         wr_data,
    output rxf_cfg_t            cfg,
    output logic [TBL_BITS-1:0] tbl
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en && wr_addr == REG_AW'(CFG_WORD)) begin
            cfg.uc_hash_en  <= wr_data[CFG_UC_BIT];
            cfg.mc_hash_en  <= wr_data[CFG_MC_BIT];
            cfg.bcast_block <= wr_data[CFG_BLOCK_BIT];
            cfg.accept_all  <= wr_data[CFG_ALL_BIT];
        end
    end

    for (genvar w = 0; w < TBL_WORDS; w++) begin : g_tbl_word
        localparam int LO = w * 32;
        localparam int NB = (TBL_BITS - LO) < 32 ? (TBL_BITS - LO) : 32;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tbl[LO +: NB] <= '0;
            end else if (wr_en && wr_addr == REG_AW'(TABLE_BASE + w)) begin
                tbl[LO +: NB] <= wr_data[NB-1:0];
            end
        end
    end

endmodule

// File: rtl/rxf_entry_bank.sv
module rxf_entry_bank
    import rxf_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int REG_AW      = 5,
    parameter int DA_W        = 48,
    localparam int HI_W       = DA_W - 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [REG_AW-1:0]      wr_addr,
    input  logic [31:0]            wr_data,
    input  logic [DA_W-1:0]        da,
    output logic [NUM_ENTRIES-1:0] slot_vld,
    output logic [NUM_ENTRIES-1:0] slot_match
);

    for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_slot
        localparam int LO_ADDR = ENTRY_BASE + 2 * k;
        localparam int HI_ADDR = ENTRY_BASE + 2 * k + 1;

        logic [31:0]     lo_q;
        logic [HI_W-1:0] hi_q;
        logic            wr_lo;
        logic            wr_hi;

        assign wr_lo = wr_en && (wr_addr == REG_AW'(LO_ADDR));
        assign wr_hi = wr_en && (wr_addr == REG_AW'(HI_ADDR));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q        <= '0;
                hi_q        <= '0;
                slot_vld[k] <= 1'b0;
            end else begin
                if (wr_lo) begin
                    lo_q        <= wr_data;
                    slot_vld[k] <= 1'b0;
                end
                if (wr_hi) begin
                    hi_q        <= wr_data[HI_W-1:0];
                    slot_vld[k] <= 1'b1;
                end
            end
        end

        assign slot_match[k] = slot_vld[k] && (da == {hi_q, lo_q});
    end

endmodule

// File: rtl/rxf_hash_fold.sv
module rxf_hash_fold #(
    parameter int DA_W   = 48,
    parameter int HASH_W = 6
) (
    input  logic [DA_W-1:0]   da,
    output logic [HASH_W-1:0] idx
);

    localparam int FOLDS = (DA_W + HASH_W - 1) / HASH_W;

    for (genvar i = 0; i < HASH_W; i++) begin : g_bit
        always_comb begin
            idx[i] = 1'b0;
            for (int j = 0; j < FOLDS; j++) begin
                if (i + j * HASH_W < DA_W) begin
                    idx[i] = idx[i] ^ da[i + j * HASH_W];
                end
            end
        end
    end

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int DA_W        = 48,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   da_valid,
    input  logic [DA_W-1:0]        da,
    input  logic [NUM_ENTRIES-1:0] slot_match,
    input  logic                   tbl_bit,
    input  rxf_cfg_t               cfg,
    output logic                   res_valid,
    output logic                   accept,
    output logic                   hit_spec,
    output logic [IDX_W-1:0]       hit_idx,
    output logic                   hit_hash,
    output logic                   hit_bcast,
    output logic                   hit_all
);

    rxf_state_e state_q;
    rxf_state_e state_d;

    logic             is_bcast;
    logic             is_group;
    logic             spec_d;
    logic [IDX_W-1:0] idx_d;
    logic             hash_d;
    logic             bcast_d;
    logic             all_d;
    logic             acc_d;

    always_comb begin
        is_bcast = &da;
        is_group = da[0];
        spec_d   = (|slot_match) && !is_bcast;
        idx_d    = '0;
        for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
            if (slot_match[k]) begin
                idx_d = IDX_W'(k);
            end
        end
        hash_d  = !is_bcast && tbl_bit &&
                  (is_group ? cfg.mc_hash_en : cfg.uc_hash_en);
        bcast_d = is_bcast && !cfg.bcast_block;
        all_d   = cfg.accept_all;
        acc_d   = spec_d || hash_d || bcast_d || all_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (da_valid)  state_d = ST_REPORT;
            ST_REPORT: if (!da_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept    <= 1'b0;
            hit_spec  <= 1'b0;
            hit_idx   <= '0;
            hit_hash  <= 1'b0;
            hit_bcast <= 1'b0;
            hit_all   <= 1'b0;
        end else if (state_d == ST_REPORT) begin
            accept    <= acc_d;
            hit_spec  <= spec_d;
            hit_idx   <= spec_d ? idx_d : '0;
            hit_hash  <= hash_d;
            hit_bcast <= bcast_d;
            hit_all   <= all_d;
        end else begin
            accept    <= 1'b0;
            hit_spec  <= 1'b0;
            hit_idx   <= '0;
            hit_hash  <= 1'b0;
            hit_bcast <= 1'b0;
            hit_all   <= 1'b0;
        end
    end

    assign res_valid = (state_q == ST_REPORT);

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int REG_AW      = 5,
    parameter int HASH_W      = 6,
    parameter int DA_W        = 48,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int TBL_BITS   = 1 << HASH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [REG_AW-1:0] cfg_wr_addr,
    input  logic [31:0]       cfg_wr_data,
    input  logic              da_valid,
    input  logic [DA_W-1:0]   da,
    output logic              res_valid,
    output logic              accept,
    output logic              hit_spec,
    output logic [IDX_W-1:0]  hit_idx,
    output logic              hit_hash,
    output logic              hit_bcast,
    output logic              hit_all
);

    rxf_cfg_t               cfg;
    logic [TBL_BITS-1:0]    tbl;
    logic [HASH_W-1:0]      hash_idx;
    logic [NUM_ENTRIES-1:0] entry_vld;
    logic [NUM_ENTRIES-1:0] entry_match;

    rxf_cfg_regs #(.REG_AW(REG_AW), .HASH_W(HASH_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_wr_addr),
        .wr_data (cfg_wr_data),
        .cfg     (cfg),
        .tbl     (tbl)
    );

    rxf_entry_bank #(.NUM_ENTRIES(NUM_ENTRIES), .REG_AW(REG_AW), .DA_W(DA_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_addr    (cfg_wr_addr),
        .wr_data    (cfg_wr_data),
        .da         (da),
        .slot_vld   (entry_vld),
        .slot_match (entry_match)
    );

    rxf_hash_fold #(.DA_W(DA_W), .HASH_W(HASH_W)) u_hash (
        .da  (da),
        .idx (hash_idx)
    );

    rxf_decide #(.NUM_ENTRIES(NUM_ENTRIES), .DA_W(DA_W)) u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .da_valid   (da_valid),
        .da         (da),
        .slot_match (entry_match),
        .tbl_bit    (tbl[hash_idx]),
        .cfg        (cfg),
        .res_valid  (res_valid),
        .accept     (accept),
        .hit_spec   (hit_spec),
        .hit_idx    (hit_idx),
        .hit_hash   (hit_hash),
        .hit_bcast  (hit_bcast),
        .hit_all    (hit_all)
    );

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
    import rxf_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int REG_AW      = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_wr_en,
    input logic [REG_AW-1:0]      cfg_wr_addr,
    input logic                   da_valid,
    input logic                   res_valid,
    input logic                   accept,
    input logic                   hit_spec,
    input logic                   hit_hash,
    input logic                   hit_bcast,
    input logic                   hit_all,
    input logic [NUM_ENTRIES-1:0] entry_vld
);

    p_valid_lag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |=> res_valid);

    p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> !res_valid);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(accept || hit_spec || hit_hash || hit_bcast || hit_all));

    p_all_accepts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_all |-> accept);

    p_bcast_accepts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_bcast |-> accept && !hit_spec && !hit_hash);

    p_reason_given_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (hit_spec || hit_hash || hit_bcast || hit_all));

    for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_slot_chk
        p_low_disables_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr_en && cfg_wr_addr == REG_AW'(ENTRY_BASE + 2 * k)) |=> !entry_vld[k]);
        p_high_enables_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr_en && cfg_wr_addr == REG_AW'(ENTRY_BASE + 2 * k + 1)) |=> entry_vld[k]);
    end

endmodule

bind rx_addr_filter rxf_checker #(.NUM_ENTRIES(NUM_ENTRIES), .REG_AW(REG_AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_addr (cfg_wr_addr),
    .da_valid    (da_valid),
    .res_valid   (res_valid),
    .accept      (accept),
    .hit_spec    (hit_spec),
    .hit_hash    (hit_hash),
    .hit_bcast   (hit_bcast),
    .hit_all     (hit_all),
    .entry_vld   (entry_vld)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [4:0]  cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        res_valid, accept, hit_spec, hit_hash, hit_bcast, hit_all;
    logic [1:0]  hit_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state, driven only by the requirements
    logic [3:0]  m_cfg;
    logic [63:0] m_tbl;
    logic [47:0] m_ent [NE];
    logic        m_ev  [NE];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .da_valid(da_valid), .da(da),
        .res_valid(res_valid), .accept(accept), .hit_spec(hit_spec), .hit_idx(hit_idx),
        .hit_hash(hit_hash), .hit_bcast(hit_bcast), .hit_all(hit_all)
    );

    function automatic logic [5:0] fold(input logic [47:0] a);
        logic [5:0] r = '0;
        for (int b = 0; b < 48; b++) r[b % 6] ^= a[b];
        return r;
    endfunction

    function automatic logic [7:0] expect_vec(input logic [47:0] a);
        logic bc, sp, hh, bh, al;
        logic [1:0] ix;
        bc = (a == BCAST);
        sp = 1'b0; ix = '0;
        for (int k = NE - 1; k >= 0; k--)
            if (m_ev[k] && m_ent[k] == a && !bc) begin sp = 1'b1; ix = 2'(k); end
        hh = !bc && m_tbl[fold(a)] && (a[0] ? m_cfg[1] : m_cfg[0]);
        bh = bc && !m_cfg[2];
        al = m_cfg[3];
        return {1'b1, (sp | hh | bh | al), sp, ix, hh, bh, al};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (valid,acc,spec,idx,hash,bcast,all)", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = 5'(addr); cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (addr == 0) m_cfg = data[3:0];
        else if (addr == 2) m_tbl[31:0] = data;
        else if (addr == 3) m_tbl[63:32] = data;
        else if (addr >= 4 && addr < 4 + 2 * NE) begin
            if (addr % 2 == 0) begin
                m_ent[(addr-4)/2][31:0] = data; m_ev[(addr-4)/2] = 1'b0;
            end else begin
                m_ent[(addr-4)/2][47:32] = data[15:0]; m_ev[(addr-4)/2] = 1'b1;
            end
        end
    endtask

    task automatic frame(input logic [47:0] a, input string req);
        logic [7:0] exp;
        @(negedge clk);
        da_valid = 1'b1; da = a;
        exp = expect_vec(a);
        @(negedge clk);
        da_valid = 1'b0;
        check(req, {res_valid, accept, hit_spec, hit_idx, hit_hash, hit_bcast, hit_all}, exp);
        @(negedge clk);
        check({req, " idle"}, {res_valid, accept, hit_spec, hit_idx, hit_hash, hit_bcast, hit_all}, 8'h00);
    endtask

    task automatic set_entry(input int k, input logic [47:0] a, input logic [15:0] junk);
        wr(4 + 2 * k, a[31:0]);
        wr(5 + 2 * k, {junk, a[47:32]});
    endtask

    task automatic t_reset_r13;
        check("R13 reset outputs", {res_valid, accept, hit_spec, hit_idx, hit_hash, hit_bcast, hit_all}, 8'h00);
        frame(48'h0000_0000_1234, "R13 unicast rejected after reset");
        frame(48'h0000_0000_1235, "R13 multicast rejected after reset");
        frame(BCAST, "R13 R3 broadcast accepted after reset");
    endtask

    task automatic t_spec_r4;
        set_entry(1, 48'h5544_3322_1100, 16'hABCD);
        frame(48'h5544_3322_1100, "R4 R11 slot 1 exact match");
        frame(48'hD544_3322_1100, "R4 bit 47 differs");
        frame(48'h5544_3322_1101, "R4 bit 0 differs");
    endtask

    task automatic t_prio_r6;
        set_entry(3, 48'h5544_3322_1100, 16'h0000);
        frame(48'h5544_3322_1100, "R6 slots 1 and 3 report 1");
        set_entry(0, 48'h5544_3322_1100, 16'hFFFF);
        frame(48'h5544_3322_1100, "R6 slots 0,1,3 report 0");
    endtask

    task automatic t_enable_r5;
        wr(4, 32'h3322_1100);
        frame(48'h5544_3322_1100, "R5 slot 0 disabled by low write");
        wr(6, 32'h3322_1100);
        frame(48'h5544_3322_1100, "R5 slot 1 disabled, slot 3 remains");
        wr(7, 32'h0000_5544);
        frame(48'h5544_3322_1100, "R5 slot 1 re-enabled by high write");
    endtask

    task automatic t_hash_r7_r8;
        logic [47:0] ua;
        logic [5:0]  ix;
        ua = 48'h0123_4567_89AA;
        ix = fold(ua);
        wr(0, 32'h1);
        if (ix < 32) wr(2, 32'h1 << ix); else wr(3, 32'h1 << (ix - 32));
        frame(ua, "R7 R8 unicast hash hit");
        frame(ua ^ 48'h0000_0000_0002, "R7 index moves with bit 1");
        frame(ua ^ 48'h0000_0000_0082, "R7 bits 1 and 7 cancel");
        frame(ua | 48'h1, "R9 multicast with mc hash off");
        wr(0, 32'h0);
        frame(ua, "R8 unicast hash disabled");
    endtask

    task automatic t_hash_r9_r10;
        logic [47:0] ma;
        ma = 48'h0000_0000_0021;
        wr(2, 32'h0); wr(3, 32'h0);
        wr(0, 32'h2);
        frame(ma, "R10 table clear");
        wr(3, 32'h1 << (fold(ma) - 32));
        frame(ma, "R9 R10 multicast hit in upper word");
        wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF);
        frame(48'h7A3C_9E10_4F57, "R9 full table accepts multicast");
        frame(48'h7A3C_9E10_4F56, "R8 full table unicast with uc off");
    endtask

    task automatic t_bcast_r3_r2;
        wr(0, 32'h4);
        frame(BCAST, "R3 broadcast blocked");
        wr(0, 32'h6);
        frame(BCAST, "R3 broadcast blocked despite full mc table");
        wr(0, 32'hC);
        frame(BCAST, "R2 copy-all overrides block");
        frame(48'h0A0B_0C0D_0E10, "R2 copy-all accepts any unicast");
        wr(0, 32'h0);
    endtask

    task automatic t_same_cycle_r12;
        logic [7:0] exp;
        @(negedge clk);
        da_valid = 1'b1; da = 48'h0000_0000_4444;
        cfg_wr_en = 1'b1; cfg_wr_addr = 5'd0; cfg_wr_data = 32'h8;
        exp = expect_vec(48'h0000_0000_4444);
        @(negedge clk);
        da_valid = 1'b0; cfg_wr_en = 1'b0; m_cfg = 4'h8;
        check("R12 write in strobe cycle ignored",
              {res_valid, accept, hit_spec, hit_idx, hit_hash, hit_bcast, hit_all}, exp);
        frame(48'h0000_0000_4444, "R12 write applies to next frame");
        wr(0, 32'h0);
    endtask

    task automatic t_back_to_back_r1;
        logic [7:0] e1, e2;
        @(negedge clk);
        da_valid = 1'b1; da = BCAST; e1 = expect_vec(BCAST);
        @(negedge clk);
        check("R1 first of back-to-back", {res_valid, accept, hit_spec, hit_idx, hit_hash, hit_bcast, hit_all}, e1);
        da = 48'h0000_0000_0100; e2 = expect_vec(48'h0000_0000_0100);
        @(negedge clk);
        da_valid = 1'b0;
        check("R1 second of back-to-back", {res_valid, accept, hit_spec, hit_idx, hit_hash, hit_bcast, hit_all}, e2);
        @(negedge clk);
        check("R1 drain to idle", {res_valid, accept, hit_spec, hit_idx, hit_hash, hit_bcast, hit_all}, 8'h00);
    endtask

    initial begin
        m_cfg = '0; m_tbl = '0;
        for (int k = 0; k < NE; k++) begin m_ent[k] = '0; m_ev[k] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r13();
        t_spec_r4();
        t_prio_r6();
        t_enable_r5();
        t_hash_r7_r8();
        t_hash_r9_r10();
        t_bcast_r3_r2();
        t_same_cycle_r12();
        t_back_to_back_r1();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule